// File: doc/BRIEF.md
# Command Buffer Power-State Controller

This block decides, cycle by cycle, how the registered address/command stage of a memory-module buffer behaves under its power-saving schemes. It sits beside the command pipeline and decides four things: whether the chip-select-gated output group and the always-driven output group are enabled or floated, what the forwarded clock-enable copies carry, whether input termination is on, and whether incoming commands are captured and forwarded. It also registers the forwarded command word and the error level.

Four mechanisms are layered in strict priority. An active-low reset overrides everything. A clock-stopped indication puts the block into standby, and a stabilisation wait of a parameterised length follows before commands flow again. Clock-enable power down is entered when both clock enables fall low, and inside it commands that carry a chip select still pass through. In normal operation, optional chip-select float gating floats the gated outputs whenever no chip select is active. Three configuration bits are held in a small control-word register. Only reset clears that register.

Top module: `cmdbuf_pwr_ctl`

## Requirements
- R1: While `rst_n` is low, the outputs respond at once: both output-enable outputs are 0, `q_cke_o` is all zeros, `err_o` is 1, `ibt_en_o` is 0, `cmd_live_o` is 0 and `state_o` is 4'b0001.
- R2: After a rising clock edge on which `clk_stop_i` is sampled 1, `state_o` is 4'b0010, both output enables are 0, `q_cke_o` is all zeros and `cmd_live_o` is 0.
- R3: Call the first edge on which `clk_stop_i` is sampled 0 after standby e0. `state_o` stays 4'b0010 and `q_cke_o` stays zero through edge e0+STAB_CYC-1. After edge e0+STAB_CYC the state is normal.
- R4: The control word is {ibt_off (bit 2), pd_en (bit 1), float_en (bit 0)}. It is loaded from `cw_d_i` on an edge with `cw_we_i`=1 only in normal or power-down state with `clk_stop_i`=0. Writes during standby or the stabilisation wait are ignored. The stored value survives standby, and reset clears it to 0.
- R5: In normal state, every edge loads `q_cmd_o` from `cmd_i` and sets `q_cke_o[CKE_W*g+i]` = `cke_i[i]` for every copy g. `cmd_live_o` and `oe_ungated_o` are 1. With float_en=1, `oe_gated_o` is 0 after an edge on which all `cs_n_i` bits are 1, and 1 after an edge on which any bit is 0.
- R6: With float_en=0, `oe_gated_o` is 1 in normal state whatever `cs_n_i` is.
- R7: With pd_en=0, a fall of both clock enables to low leaves the state normal and forwards the zeros.
- R8: With pd_en=1 in normal state, power down (`state_o`=4'b0100) is entered after an edge on which `cke_i`==0 and `cke_i` was nonzero on the previous edge. Enables that are held low steadily do not enter it.
- R9: In power down `q_cke_o` is all zeros. On an edge where any chip select is 0, the command is captured into `q_cmd_o` and `oe_gated_o` and `cmd_live_o` are 1. Otherwise both are 0 and `q_cmd_o` holds its value.
- R10: `ibt_en_o` is 0 in power down when ibt_off=1, and 1 in power down when ibt_off=0, in normal state and in standby.
- R11: Power down ends after the first edge on which any `cke_i` bit is 1. On that edge the state returns to normal and `q_cke_o` follows `cke_i`.
- R12: The clock-stop indication overrides power down and takes the block to standby. Reset overrides every state.
- R13: Outside reset, `err_o` equals `err_n_i` as sampled on the previous edge.
- R14: `state_o` is always one-hot: bit 0 reset, bit 1 standby (including the wait), bit 2 power down, bit 3 normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_stop_i | input | 1 | Clock-stopped indication |
| cke_i | input | CKE_W | Clock-enable inputs |
| cs_n_i | input | NCS | Active-low chip selects |
| cmd_i | input | CMD_W | Command/address word |
| err_n_i | input | 1 | Error level to be registered |
| cw_we_i | input | 1 | Control-word write strobe |
| cw_d_i | input | 3 | Control-word write data |
| q_cmd_o | output | CMD_W | Forwarded command word |
| q_cke_o | output | CKE_W*CKE_COPIES | Forwarded clock-enable copies |
| oe_gated_o | output | 1 | Enable for the chip-select-gated output group |
| oe_ungated_o | output | 1 | Enable for the always-driven output group |
| err_o | output | 1 | Registered error output level |
| ibt_en_o | output | 1 | Input-termination enable |
| cmd_live_o | output | 1 | Command path forwarding this cycle |
| state_o | output | 4 | One-hot power state |

## Verification
A vector table drives the normal-mode forwarding with every chip select high, then with one chip select low, then with several low, and with all three nonzero clock-enable patterns. This separates the float decision from the forwarding of commands and enables. Directed sequences then test a falling enable pair against a steadily low one and power down with and without a chip select. They also test each setting of the termination and power-down bits, and a clock stop issued during power down. A control-word write attempted during the standby and wait phases must leave no trace on the float or power-down behaviour that follows. A reset during power down must clear the control word.

// File: rtl/cmdbuf_pwr_pkg.sv
package cmdbuf_pwr_pkg;
   typedef enum logic [2:0] {
      ST_RST  = 3'd0,
      ST_STBY = 3'd1,
      ST_WAIT = 3'd2,
      ST_PD   = 3'd3,
      ST_RUN  = 3'd4
   } pwr_st_e;

   localparam int CW_W      = 3;
   localparam int CW_FLOAT  = 0;
   localparam int CW_PDEN   = 1;
   localparam int CW_IBTOFF = 2;
endpackage

// File: rtl/cke_fall_det.sv
module cke_fall_det #(
   parameter int CKE_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CKE_W-1:0] cke_i,
   output logic             fall_o,
   output logic             any_hi_o
);
   logic [CKE_W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= cke_i;
   end

   assign any_hi_o = |cke_i;
   assign fall_o   = !any_hi_o && (|prev_q);
endmodule

// File: rtl/stab_timer.sv
module stab_timer #(
   parameter int STAB_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic done_o
);
   localparam int CNT_W = $clog2(STAB_CYC + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(STAB_CYC - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (!run_i)         cnt_q <= '0;
      else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
   end

   assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
   import cmdbuf_pwr_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    clk_stop_i,
   input  logic    pd_en_i,
   input  logic    fall_i,
   input  logic    any_hi_i,
   input  logic    stab_done_i,
   output pwr_st_e st_o,
   output pwr_st_e nxt_o
);
   pwr_st_e st_q;

   always_comb begin
      nxt_o = st_q;
      if (clk_stop_i) begin
         nxt_o = ST_STBY;
      end else begin
         case (st_q)
            ST_RST:  nxt_o = ST_RUN;
            ST_STBY: nxt_o = ST_WAIT;
            ST_WAIT: nxt_o = stab_done_i ? ST_RUN : ST_WAIT;
            ST_RUN:  nxt_o = (pd_en_i && fall_i) ? ST_PD : ST_RUN;
            ST_PD:   nxt_o = any_hi_i ? ST_RUN : ST_PD;
            default: nxt_o = ST_RST;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_RST;
      else        st_q <= nxt_o;
   end

   assign st_o = st_q;
endmodule

// File: rtl/cmdbuf_pwr_ctl.sv
module cmdbuf_pwr_ctl
   import cmdbuf_pwr_pkg::*;
#(
   parameter int CMD_W      = 8,
   parameter int NCS        = 4,
   parameter int CKE_W      = 2,
   parameter int CKE_COPIES = 2,
   parameter int STAB_CYC   = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clk_stop_i,
   input  logic [CKE_W-1:0]            cke_i,
   input  logic [NCS-1:0]              cs_n_i,
   input  logic [CMD_W-1:0]            cmd_i,
   input  logic                        err_n_i,
   input  logic                        cw_we_i,
   input  logic [2:0]                  cw_d_i,
   output logic [CMD_W-1:0]            q_cmd_o,
   output logic [CKE_W*CKE_COPIES-1:0] q_cke_o,
   output logic                        oe_gated_o,
   output logic                        oe_ungated_o,
   output logic                        err_o,
   output logic                        ibt_en_o,
   output logic                        cmd_live_o,
   output logic [3:0]                  state_o
);
   localparam int QCKE_W = CKE_W * CKE_COPIES;

   if (STAB_CYC < 1)   begin : g_bad_stab  $error("STAB_CYC must be at least 1"); end
   if (NCS < 1)        begin : g_bad_ncs   $error("NCS must be at least 1"); end
   if (CKE_W < 1)      begin : g_bad_cke   $error("CKE_W must be at least 1"); end
   if (CKE_COPIES < 1) begin : g_bad_copy  $error("CKE_COPIES must be at least 1"); end
   if (CMD_W < 1)      begin : g_bad_cmd   $error("CMD_W must be at least 1"); end

   pwr_st_e          st, nxt;
   logic             fall, any_hi, stab_done;
   logic [CW_W-1:0]  cw_q;
   logic             any_cs, all_cs_hi, fwd_nxt;
   logic [CKE_W-1:0] cke_q;

   cke_fall_det #(.CKE_W(CKE_W)) i_fall (
      .clk(clk), .rst_n(rst_n), .cke_i(cke_i), .fall_o(fall), .any_hi_o(any_hi)
   );

   stab_timer #(.STAB_CYC(STAB_CYC)) i_timer (
      .clk(clk), .rst_n(rst_n), .run_i(st == ST_WAIT), .done_o(stab_done)
   );

   pwr_fsm i_fsm (
      .clk(clk), .rst_n(rst_n), .clk_stop_i(clk_stop_i), .pd_en_i(cw_q[CW_PDEN]),
      .fall_i(fall), .any_hi_i(any_hi), .stab_done_i(stab_done),
      .st_o(st), .nxt_o(nxt)
   );

   assign all_cs_hi = &cs_n_i;
   assign any_cs    = !all_cs_hi;
   assign fwd_nxt   = (nxt == ST_RUN) || ((nxt == ST_PD) && any_cs);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cw_q <= '0;
      end else if (cw_we_i && !clk_stop_i && (st == ST_RUN || st == ST_PD)) begin
         cw_q <= cw_d_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_ungated_o <= 1'b0;
         oe_gated_o   <= 1'b0;
         cmd_live_o   <= 1'b0;
         q_cmd_o      <= '0;
         cke_q        <= '0;
         err_o        <= 1'b1;
      end else begin
         oe_ungated_o <= (nxt == ST_RUN) || (nxt == ST_PD);
         oe_gated_o   <= ((nxt == ST_RUN) && !(cw_q[CW_FLOAT] && all_cs_hi))
                         || ((nxt == ST_PD) && any_cs);
         cmd_live_o   <= fwd_nxt;
         if (fwd_nxt) q_cmd_o <= cmd_i;
         cke_q        <= (nxt == ST_RUN) ? cke_i : '0;
         err_o        <= err_n_i;
      end
   end

   for (genvar g = 0; g < CKE_COPIES; g++) begin : g_cke_copy
      assign q_cke_o[g*CKE_W +: CKE_W] = cke_q;
   end

   assign ibt_en_o = (st != ST_RST) && !((st == ST_PD) && cw_q[CW_IBTOFF]);

   assign state_o = {st == ST_RUN, st == ST_PD,
                     (st == ST_STBY) || (st == ST_WAIT), st == ST_RST};

   logic unused_w;
   assign unused_w = ^{QCKE_W};
endmodule

// File: rtl/cmdbuf_pwr_chk.sv
module cmdbuf_pwr_chk #(
   parameter int CKE_W  = 2,
   parameter int QCKE_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clk_stop_i,
   input logic [CKE_W-1:0]  cke_i,
   input logic [2:0]        cw_q,
   input logic [QCKE_W-1:0] q_cke_o,
   input logic              oe_gated_o,
   input logic              oe_ungated_o,
   input logic              err_o,
   input logic              ibt_en_o,
   input logic [3:0]        state_o
);
   always @(negedge clk) begin
      if (!rst_n) begin
         p_rst_prio_r1: assert (q_cke_o == '0 && !oe_gated_o && !oe_ungated_o
                                && err_o && !ibt_en_o && state_o == 4'b0001);
      end
      p_onehot_r14: assert ($countones(state_o) == 1);
   end

   p_stby_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clk_stop_i |=> (state_o == 4'b0010 && q_cke_o == '0 && !oe_gated_o && !oe_ungated_o));

   p_cw_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      state_o[1] |=> $stable(cw_q));

   p_pd_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o[3] && !clk_stop_i && cw_q[1] && cke_i == '0 && $past(cke_i) != '0)
      |=> state_o[2]);

   p_pd_cke_r9: assert property (@(posedge clk) disable iff (!rst_n)
      state_o[2] |-> q_cke_o == '0);

   p_pd_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o[2] && !clk_stop_i && cke_i != '0) |=> state_o[3]);
endmodule

bind cmdbuf_pwr_ctl cmdbuf_pwr_chk #(.CKE_W(CKE_W), .QCKE_W(CKE_W*CKE_COPIES)) i_chk (
   .clk(clk), .rst_n(rst_n), .clk_stop_i(clk_stop_i), .cke_i(cke_i), .cw_q(cw_q),
   .q_cke_o(q_cke_o), .oe_gated_o(oe_gated_o), .oe_ungated_o(oe_ungated_o),
   .err_o(err_o), .ibt_en_o(ibt_en_o), .state_o(state_o)
);

// File: tb/test_cmdbuf_pwr_ctl.sv
module test_cmdbuf_pwr_ctl;
   logic       clk = 0;
   logic       rst_n = 0;
   logic       clk_stop = 0;
   logic [1:0] cke = 0;
   logic [3:0] cs_n = 4'hF;
   logic [7:0] cmd = 0;
   logic       err_n = 1;
   logic       cw_we = 0;
   logic [2:0] cw_d = 0;
   logic [7:0] q_cmd;
   logic [3:0] q_cke;
   logic       oeg, oeu, err, ibt, live;
   logic [3:0] st;
   int checks = 0, errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   cmdbuf_pwr_ctl i_cmdbuf_pwr_ctl (
      .clk(clk), .rst_n(rst_n), .clk_stop_i(clk_stop), .cke_i(cke), .cs_n_i(cs_n),
      .cmd_i(cmd), .err_n_i(err_n), .cw_we_i(cw_we), .cw_d_i(cw_d),
      .q_cmd_o(q_cmd), .q_cke_o(q_cke), .oe_gated_o(oeg), .oe_ungated_o(oeu),
      .err_o(err), .ibt_en_o(ibt), .cmd_live_o(live), .state_o(st)
   );

   // {cs_n[19:16], cke[15:14], cmd[13:6], exp oe_gated[5], exp q_cke[4:1], exp live[0]}
   localparam logic [19:0] TBL [6] = '{
      {4'b1111, 2'b11, 8'hA5, 1'b0, 4'b1111, 1'b1},
      {4'b1110, 2'b01, 8'h3C, 1'b1, 4'b0101, 1'b1},
      {4'b0111, 2'b10, 8'h5A, 1'b1, 4'b1010, 1'b1},
      {4'b1111, 2'b11, 8'h0F, 1'b0, 4'b1111, 1'b1},
      {4'b0000, 2'b01, 8'hF0, 1'b1, 4'b0101, 1'b1},
      {4'b1011, 2'b11, 8'h81, 1'b1, 4'b1111, 1'b1}
   };

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic wr_cw(logic [2:0] v);
      cw_we = 1; cw_d = v;
      step();
      cw_we = 0;
   endtask

   initial begin
      repeat (3000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) step();
      // R1 reset state
      chk("R1 outputs", {q_cke, oeg, oeu, err, ibt, live}, {4'b0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0});
      chk("R1 state", st, 4'b0001);
      rst_n = 1;
      step();
      chk("R14 normal after reset", st, 4'b1000);
      chk("R6 float off after reset", {oeg, oeu, ibt}, 3'b111);
      chk("R13 err follows", err, 1'b1);
      wr_cw(3'b011);
      repeat (2) step();
      chk("R8 steady low no entry", st, 4'b1000);

      // R5 table walk
      for (int i = 0; i < 6; i++) begin
         cs_n = TBL[i][19:16]; cke = TBL[i][15:14]; cmd = TBL[i][13:6];
         step();
         chk("R5 oe_gated", oeg, TBL[i][5]);
         chk("R5 q_cke", q_cke, TBL[i][4:1]);
         chk("R5 live", live, TBL[i][0]);
         chk("R5 q_cmd", q_cmd, TBL[i][13:6]);
      end

      cs_n = 4'hF;
      wr_cw(3'b010);
      step();
      chk("R6 float off all cs high", oeg, 1'b1);

      cke = 2'b00; step();
      chk("R8 enter pd", st, 4'b0100);
      chk("R9 pd no cs", {q_cke, oeg, live}, {4'b0000, 1'b0, 1'b0});
      chk("R9 q_cmd held", q_cmd, 8'h81);
      chk("R10 ibt kept", ibt, 1'b1);
      cs_n = 4'b1101; cmd = 8'h77; step();
      chk("R9 pd with cs", {q_cke, oeg, live, oeu}, {4'b0000, 1'b1, 1'b1, 1'b1});
      chk("R9 q_cmd", q_cmd, 8'h77);
      cs_n = 4'hF; cke = 2'b10; step();
      chk("R11 exit state", st, 4'b1000);
      chk("R11 exit cke", q_cke, 4'b1010);

      wr_cw(3'b110);
      cke = 2'b00; step();
      chk("R10 pd state", st, 4'b0100);
      chk("R10 ibt off", ibt, 1'b0);
      cke = 2'b01; step();
      chk("R11 ibt back", {st, ibt, q_cke}, {4'b1000, 1'b1, 4'b0101});

      wr_cw(3'b100);
      cke = 2'b11; step();
      cke = 2'b00; step();
      chk("R7 no pd", st, 4'b1000);
      chk("R7 zeros forwarded", {q_cke, ibt}, {4'b0000, 1'b1});

      wr_cw(3'b010);
      cke = 2'b11; step();
      cke = 2'b00; step();
      chk("R12 pd before stop", st, 4'b0100);
      clk_stop = 1; cw_we = 1; cw_d = 3'b001; step();
      chk("R12 stop over pd", st, 4'b0010);
      chk("R2 standby outputs", {q_cke, oeg, oeu, live}, {4'b0000, 1'b0, 1'b0, 1'b0});
      step();
      chk("R2 standby held", st, 4'b0010);
      clk_stop = 0; cke = 2'b11;
      for (int k = 0; k < 4; k++) begin
         step();
         chk("R3 wait", {st, q_cke, live}, {4'b0010, 4'b0000, 1'b0});
      end
      cw_we = 0;
      step();
      chk("R3 normal after wait", {st, q_cke}, {4'b1000, 4'b1111});
      step();
      chk("R4 float bit kept", oeg, 1'b1);
      cke = 2'b00; step();
      chk("R4 pd bit kept", st, 4'b0100);

      err_n = 0; step();
      chk("R13 err low", err, 1'b0);
      rst_n = 0; #1;
      chk("R12 reset over pd", st, 4'b0001);
      chk("R1 reset outputs", {q_cke, oeg, oeu, err, ibt}, {4'b0000, 1'b0, 1'b0, 1'b1, 1'b0});
      err_n = 1;
      repeat (2) step();
      rst_n = 1; cke = 2'b11; step();
      cke = 2'b00; step();
      chk("R4 reset cleared pd bit", st, 4'b1000);
      chk("R4 reset cleared float bit", oeg, 1'b1);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule